// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters on a single output line. A byte is first written into a holding register. When the output shifter is free and the far end allows sending, the byte moves into the shifter. The holding register is then free again, so the host can queue the next byte while the current character is still going out. When a byte is already waiting at the moment a character ends, the next character starts on the next bit slot, with no idle time between the two.

Timing comes from a one-cycle bit-rate enable, which a baud generator outside the block supplies. Each bit on the line lasts from one enable pulse to the next. A 3-bit format code sets three things for every character: 7 or 8 data bits, no parity or even or odd parity, and one or two stop bits. A clear-to-send input gates only the start of a new character. A character that has already begun always runs to its last stop bit.

Top module: `serial_tx_queue`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `txd` is high and `hold_empty` is high.
- R2: A character is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop bits. Each bit holds from one `bit_tick` pulse to the next, and the line is high while idle.
- R3: `fmt` selects the framing: 0 = 7 data, even parity, 2 stop; 1 = 7 data, odd, 2 stop; 2 = 7 data, even, 1 stop; 3 = 7 data, odd, 1 stop; 4 = 8 data, no parity, 2 stop; 5 = 8 data, no parity, 1 stop; 6 = 8 data, even, 1 stop; 7 = 8 data, odd, 1 stop. With 7 data bits, bit 7 of the byte is not sent.
- R4: The parity bit makes the count of ones over the sent data bits plus parity even (even mode) or odd (odd mode).
- R5: A `wr_en` pulse stores `wr_data` and drives `hold_empty` low from the next clock edge on.
- R6: A waiting byte moves into the shifter at a `bit_tick` edge. At that same edge `txd` goes low for the start bit and `hold_empty` goes high.
- R7: If a byte is waiting and `cts` is high when the last stop bit ends, the next start bit follows at once, with no idle bit time.
- R8: While `cts` is low, no new character starts: `txd` stays high and a queued byte stays in the holding register (`hold_empty` low).
- R9: A character already started is sent in full even if `cts` drops while it is going out.
- R10: A write while the holding register is full replaces the waiting byte. Only the last byte written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit-time boundary |
| wr_en | input | 1 | Load strobe for the holding register |
| wr_data | input | 8 | Byte to queue |
| fmt | input | 3 | Framing code (see R3) |
| cts | input | 1 | Clear to send; high allows a new character to start |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | High when the holding register can take a byte |

## Verification
The bench sends every format code with data chosen so that both parity senses come up. A builder that got the bit count, the order or the parity sense wrong would shift the frame or flip its parity bit. Back-to-back queuing checks that the second start bit follows the last stop bit directly. A shifter that dropped back to idle for a bit slot, or lost the queued byte, would fail this check. With `cts` held low, the bench checks that the line stays high and the byte stays queued. It also overwrites the queued byte, so a design that kept the first write would send the wrong data. Dropping `cts` right after a start bit catches a design that cuts off a character already under way.

// File: rtl/tx_fmt_pkg.sv
// Shared framing types and the format-code decoder for the serial transmitter.
// Assumes a 3-bit code; every code value is defined, so no value is illegal.
package tx_fmt_pkg;

    typedef struct packed {
        logic full_width;   // 1: all data bits, 0: one bit fewer
        logic par_en;       // parity bit present
        logic par_odd;      // 1: odd parity, 0: even parity
        logic two_stop;     // 1: two stop bits
    } tx_fmt_t;

    // Map the framing code to its fields
    function automatic tx_fmt_t decode_fmt(input logic [2:0] code);
        tx_fmt_t f;
        case (code)
            3'd0:    f = '{1'b0, 1'b1, 1'b0, 1'b1};
            3'd1:    f = '{1'b0, 1'b1, 1'b1, 1'b1};
            3'd2:    f = '{1'b0, 1'b1, 1'b0, 1'b0};
            3'd3:    f = '{1'b0, 1'b1, 1'b1, 1'b0};
            3'd4:    f = '{1'b1, 1'b0, 1'b0, 1'b1};
            3'd5:    f = '{1'b1, 1'b0, 1'b0, 1'b0};
            3'd6:    f = '{1'b1, 1'b1, 1'b0, 1'b0};
            default: f = '{1'b1, 1'b1, 1'b1, 1'b0};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/tx_hold_reg.sv
// Holding register with its full flag.
// A write always lands here, even when full (it replaces the waiting byte).
// A take empties it unless a write arrives in the same cycle.
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              full
);

    // Capture written data and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            full      <= 1'b0;
        end else begin
            if (wr_en) hold_data <= wr_data;
            if (wr_en)      full <= 1'b1;
            else if (take)  full <= 1'b0;
        end
    end

    // A take only removes a byte that is present
    p_take_needs_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

    // A take with no new write leaves the register free
    p_take_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> !full);

    // A write always leaves the register occupied
    p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (full && hold_data == $past(wr_data)));

endmodule

// File: rtl/tx_frame_build.sv
// Combinational frame builder: start bit, data LSB first, optional parity,
// then stop bits, packed so that bit 0 is sent first. Unused upper bits are 1.
// Also gives the index of the last bit of the frame.
module tx_frame_build
    import tx_fmt_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W)
) (
    input  logic [2:0]        fmt,
    input  logic [DATA_W-1:0] data,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   last_idx
);

    tx_fmt_t            f;
    logic [DATA_W-1:0]  mask;
    logic               par_bit;
    int                 nbits;

    // Decode the format and work out the parity over the sent data bits
    always_comb begin
        f       = decode_fmt(fmt);
        nbits   = f.full_width ? DATA_W : DATA_W - 1;
        mask    = f.full_width ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
        par_bit = (^(data & mask)) ^ f.par_odd;
    end

    // Place start, data, parity and stop bits
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) frame[i+1] = data[i];
        end
        if (f.par_en) frame[nbits+1] = par_bit;
        last_idx = CNT_W'(nbits + int'(f.par_en) + (f.two_stop ? 2 : 1));
    end

endmodule

// File: rtl/tx_shifter.sv
// Output shift register and bit counter, stepped by the bit-rate enable.
// On a tick it either starts a frame (when idle or on the last bit, with
// 'ready' high) or shifts one bit out. A running frame ignores 'ready'.
module tx_shifter #(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               ready,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   last_idx,
    output logic               take,
    output logic               busy,
    output logic               txd
);

    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic               at_end;

    // Decide whether this tick starts a new frame
    always_comb begin
        at_end = busy && (cnt == '0);
        take   = bit_tick && (!busy || at_end) && ready;
    end

    // Load, shift and end frames on bit ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (bit_tick) begin
            if (take) begin
                sh   <= frame;
                cnt  <= last_idx;
                busy <= 1'b1;
            end else if (at_end) begin
                sh   <= '1;
                busy <= 1'b0;
            end else if (busy) begin
                sh  <= {1'b1, sh[FRAME_W-1:1]};
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign txd = sh[0];

    // Idle line is high
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // Every frame begins with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !txd);

    // The line only moves on a tick
    p_hold_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));

    // A running frame, not on its last bit, keeps going regardless of ready
    p_finish_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> busy);

endmodule

// File: rtl/serial_tx_queue.sv
// Double-buffered asynchronous serial transmitter.
// A holding register feeds a frame builder and an output shifter. A byte moves
// across when the shifter is free (or on its last bit) and cts is high.
// Assumes bit_tick is a one-cycle pulse from an external baud generator.
module serial_tx_queue #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        fmt,
    input  logic              cts,
    output logic              txd,
    output logic              hold_empty
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W);

    logic [DATA_W-1:0]  hold_data;
    logic               full;
    logic               take;
    logic               busy;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   last_idx;

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (take),
        .hold_data(hold_data),
        .full     (full)
    );

    tx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
        .fmt     (fmt),
        .data    (hold_data),
        .frame   (frame),
        .last_idx(last_idx)
    );

    tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_tick(bit_tick),
        .ready   (full && cts),
        .frame   (frame),
        .last_idx(last_idx),
        .take    (take),
        .busy    (busy),
        .txd     (txd)
    );

    assign hold_empty = !full;

    // A new character never starts while cts is low
    p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cts);

    // Hold and empty flag agree with a queued byte staying put under cts low
    p_queue_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && !cts && !wr_en) |=> !hold_empty);

endmodule

// File: tb/tb_serial_tx_queue.sv
`timescale 1ns/1ps
module tb_serial_tx_queue;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] fmt = '0;
    logic       cts = 1'b1;
    logic       txd;
    logic       hold_empty;

    int checks = 0;
    int errors = 0;
    int dcnt = 0;

    serial_tx_queue dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .fmt(fmt), .cts(cts), .txd(txd), .hold_empty(hold_empty)
    );

    always #2 clk = ~clk;

    // Bit-rate enable: one pulse every DIV clocks
    always @(negedge clk) begin
        bit_tick <= (dcnt == 0);
        dcnt     <= (dcnt == DIV-1) ? 0 : dcnt + 1;
    end

    // Vector table: {fmt, data}
    localparam logic [10:0] VEC [8] = '{
        {3'd0, 8'h5A}, {3'd1, 8'hD3}, {3'd2, 8'h01}, {3'd3, 8'h7F},
        {3'd4, 8'hA5}, {3'd5, 8'h80}, {3'd6, 8'h37}, {3'd7, 8'hC4}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected frame from the requirements (R2, R3, R4)
    task automatic exp_frame(input logic [2:0] f, input logic [7:0] d,
                             output logic [11:0] bits, output int len);
        int nb; bit par_en, odd, two; bit p;
        nb = (f < 4) ? 7 : 8;
        par_en = (f != 4 && f != 5);
        odd = (f == 1 || f == 3 || f == 7);
        two = (f == 0 || f == 1 || f == 4);
        bits = '1;
        bits[0] = 1'b0;
        p = odd;
        for (int i = 0; i < nb; i++) begin
            bits[i+1] = d[i];
            p = p ^ d[i];
        end
        len = 1 + nb;
        if (par_en) begin bits[len] = p; len++; end
        len += two ? 2 : 1;
    endtask

    task automatic load_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Sample a frame bit by bit; chained means the start bit follows the previous sample by DIV
    task automatic capture(input logic [2:0] f, input logic [7:0] d, input bit chained,
                           input bit drop, input bit chk_empty, input string req);
        logic [11:0] exp; logic [11:0] got; int len; int t;
        exp_frame(f, d, exp, len);
        got = '1;
        if (chained) repeat (DIV) @(negedge clk);
        else begin
            t = 0;
            while (txd !== 1'b0 && t < 400) begin @(negedge clk); t++; end
        end
        got[0] = txd;
        if (chk_empty) chk(hold_empty === 1'b1, "R6 empty at start", 32'(hold_empty), 1);
        if (drop) cts = 1'b0;
        for (int i = 1; i < len; i++) begin
            repeat (DIV) @(negedge clk);
            got[i] = txd;
        end
        chk(got === exp, req, 32'(got), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(txd === 1'b1, "R1 txd after reset", 32'(txd), 1);
        chk(hold_empty === 1'b1, "R1 empty after reset", 32'(hold_empty), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd === 1'b1 && hold_empty === 1'b1, "R1 idle after release", 32'({txd, hold_empty}), 3);

        // Table walk: R2, R3, R4, R5, R6
        for (int v = 0; v < 8; v++) begin
            fmt = VEC[v][10:8];
            load_byte(VEC[v][7:0]);
            chk(hold_empty === 1'b0, "R5 full after load", 32'(hold_empty), 0);
            capture(VEC[v][10:8], VEC[v][7:0], 1'b0, 1'b0, 1'b1, "R2 R3 R4 frame");
            repeat (2*DIV) @(negedge clk);
        end

        // R7: queue a second byte while the first is going out
        fmt = 3'd6;
        load_byte(8'h3C);
        while (hold_empty !== 1'b1) @(negedge clk);
        load_byte(8'hE1);
        capture(3'd6, 8'h3C, 1'b0, 1'b0, 1'b0, "R7 first frame");
        capture(3'd6, 8'hE1, 1'b1, 1'b0, 1'b0, "R7 chained frame no gap");
        repeat (3*DIV) @(negedge clk);

        // R8: cts low holds off a queued byte
        cts = 1'b0;
        fmt = 3'd5;
        load_byte(8'h11);
        repeat (40) @(negedge clk);
        chk(txd === 1'b1, "R8 line idle with cts low", 32'(txd), 1);
        chk(hold_empty === 1'b0, "R8 byte kept with cts low", 32'(hold_empty), 0);
        // R10: overwrite the waiting byte
        load_byte(8'h96);
        cts = 1'b1;
        capture(3'd5, 8'h96, 1'b0, 1'b0, 1'b1, "R10 last write sent");
        repeat (3*DIV) @(negedge clk);

        // R9: cts drops right after the start bit
        fmt = 3'd1;
        load_byte(8'h4B);
        capture(3'd1, 8'h4B, 1'b0, 1'b1, 1'b1, "R9 frame completes after cts drop");
        load_byte(8'h22);
        repeat (20*DIV) @(negedge clk);
        chk(txd === 1'b1 && hold_empty === 1'b0, "R9 R8 no new start after drop",
            32'({txd, hold_empty}), 2);
        cts = 1'b1;
        capture(3'd1, 8'h22, 1'b0, 1'b0, 1'b1, "R8 released frame");

        // R1: reset while a byte is queued
        cts = 1'b0;
        load_byte(8'h77);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(hold_empty === 1'b1 && txd === 1'b1, "R1 reset clears queue", 32'({txd, hold_empty}), 3);
        rst_n = 1'b1; cts = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule